// File: doc/BRIEF.md
# Edge-Kicked Activity Watchdog

This block watches a processor's heartbeat line and reports when the heartbeat stops. Any change of level on the heartbeat input counts as a kick, whether it rises or falls. Each kick starts a fresh countdown of `TIMEOUT_CYC` clock cycles. If the countdown runs out with no further kick, the active-low alarm output drops. The alarm stays low until the next kick. At the chip top level the alarm is typically wired back into a manual reset request, so that a stalled processor gets restarted.

Three control flags shape the behaviour. While the system reset flag is high, or while the enable flag is low, the timer is held cleared and idle. The enable flag stands for "heartbeat line is undriven". A low supply-good flag forces the alarm low at once, whatever the timer is doing, and the alarm is released in the same cycle that the supply recovers. All the control and status pins are plain level signals. There is no streaming interface, so no back-pressure applies.

Top module: `activity_watchdog`

## Requirements
- R1: After a kick has been registered at a clock edge, and with no later kick and no hold, `wdo_n` goes low exactly `TIMEOUT_CYC` clock edges later. It is still high after `TIMEOUT_CYC`-1 edges.
- R2: Once the timer has expired, `wdo_n` stays low until a kick is registered. The edge that registers the kick drives `wdo_n` high again.
- R3: A rising and a falling transition on `wdi` each count as a kick. Each one restarts the full `TIMEOUT_CYC` countdown, including when the timer is already counting.
- R4: While `sys_rst_act` is 1, the timer is cleared, so an expired state is removed and no expiry can occur. After `sys_rst_act` returns to 0, counting begins only once `wdi` changes.
- R5: While `wd_en` is 0, the timer is cleared and idle, and transitions on `wdi` are ignored. After enable, counting begins only once `wdi` changes.
- R6: When `supply_ok` is 0, `wdo_n` is 0 combinationally. When `supply_ok` returns to 1, `wdo_n` reflects the timer in the same cycle, with no minimum low time.
- R7: A kick is detected by comparing `wdi` with its value at the previous clock edge. A level held for a single cycle therefore gives two kicks, and the second one restarts the countdown.
- R8: When the timer is idle or counting and `supply_ok` is 1, `wdo_n` is 1.
- R9: The synchronous reset `rst_n` leaves the timer idle, so that `wdo_n` equals `supply_ok`. A level on `wdi` that differs at reset release does not count as a kick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wdi | input | 1 | Heartbeat input; any level change is a kick |
| sys_rst_act | input | 1 | System reset in progress; holds the timer cleared |
| wd_en | input | 1 | 0 = heartbeat line undriven; holds the timer cleared |
| supply_ok | input | 1 | Supply above threshold; 0 forces the alarm low |
| wdo_n | output | 1 | Watchdog alarm, active low |

## Verification
On every cycle, the bound checker runs its own quiet-cycle counter and compares `wdo_n` against it. This shows that the alarm is high before the counter reaches the timeout and low at the timeout (R1, R8, R9). The checker also confirms that a low supply forces the alarm low, and that a hold or a kick returns the alarm to the supply level on the next edge. Only the bench scenarios can show the following: that expiry lands on the exact edge counted from a falling or a re-kicking transition; that a one-cycle pulse restarts the countdown from its second edge; that a level change during a hold or a reset does not later count as a kick; and that the alarm stays latched low through a supply dip.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdog_edge_det.sv
module wdog_edge_det (
  input  logic clk,
  input  logic din,
  output logic kick
);
  logic din_q;

  // Tracks the input during reset as well, so release never sees a stale level.
  always_ff @(posedge clk) begin
    din_q <= din;
  end

  assign kick = din ^ din_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      kick,
  output wd_state_e state
);
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      state <= WD_IDLE;
      cnt   <= '0;
    end else if (kick) begin
      state <= WD_RUN;
      cnt   <= '0;
    end else if (state == WD_RUN) begin
      if (cnt == LAST) begin
        state <= WD_TRIP;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_out_gate.sv
module wdog_out_gate
  import wdog_pkg::*;
(
  input  wd_state_e state,
  input  logic      supply_ok,
  output logic      wdo_n
);
  always_comb begin
    wdo_n = supply_ok && (state != WD_TRIP);
  end
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic sys_rst_act,
  input  logic wd_en,
  input  logic supply_ok,
  output logic wdo_n
);
  logic      kick;
  logic      hold;
  wd_state_e tmr_state;

  assign hold = sys_rst_act || !wd_en;

  wdog_edge_det u_edge (
    .clk  (clk),
    .din  (wdi),
    .kick (kick)
  );

  wdog_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .kick  (kick),
    .state (tmr_state)
  );

  wdog_out_gate u_gate (
    .state     (tmr_state),
    .supply_ok (supply_ok),
    .wdo_n     (wdo_n)
  );
endmodule

// File: rtl/activity_watchdog_chk.sv
module activity_watchdog_chk #(
  parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic wdi,
  input logic sys_rst_act,
  input logic wd_en,
  input logic supply_ok,
  input logic wdo_n
);
  localparam int unsigned QW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(TIMEOUT_CYC);

  logic          wdi_d;
  logic          armed;
  logic [QW-1:0] quiet;
  logic          held;

  assign held = sys_rst_act || !wd_en;

  always_ff @(posedge clk) begin
    wdi_d <= wdi;
    if (!rst_n || held) begin
      armed <= 1'b0;
      quiet <= '0;
    end else if (wdi != wdi_d) begin
      armed <= 1'b1;
      quiet <= '0;
    end else if (armed && quiet != QMAX) begin
      quiet <= quiet + 1'b1;
    end
  end

  AST_TRIP_AT_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && quiet == QMAX && supply_ok) |-> !wdo_n); // R1
  AST_HIGH_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && quiet != QMAX && supply_ok) |-> wdo_n); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && supply_ok) |-> wdo_n); // R9
  AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wdo_n); // R6
  AST_RESET_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_act |=> (wdo_n == supply_ok)); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (wdo_n == supply_ok)); // R5
  AST_KICK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && wdi != wdi_d) |=> (wdo_n == supply_ok)); // R2
endmodule

bind activity_watchdog activity_watchdog_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wdi         (wdi),
  .sys_rst_act (sys_rst_act),
  .wd_en       (wd_en),
  .supply_ok   (supply_ok),
  .wdo_n       (wdo_n)
);

// File: tb/activity_watchdog_bench.sv
module activity_watchdog_bench;
  localparam int unsigned T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi = 1'b0;
  logic sys_rst_act = 1'b0;
  logic wd_en = 1'b1;
  logic supply_ok = 1'b1;
  logic wdo_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  activity_watchdog #(.TIMEOUT_CYC(T)) u_activity_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdi         (wdi),
    .sys_rst_act (sys_rst_act),
    .wd_en       (wd_en),
    .supply_ok   (supply_ok),
    .wdo_n       (wdo_n)
  );

  typedef struct packed {
    logic       wdi;
    logic       srst;
    logic       en;
    logic       sup;
    logic [7:0] cyc;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd20, 1'b1, 4'd4},  // R4 no count before first transition
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd8,  1'b1, 4'd1},  // R1 still high after T-1 quiet edges
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd1},  // R1 low on edge T
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd10, 1'b0, 4'd2},  // R2 stays low
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b1, 4'd2},  // R2 falling kick releases
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd7,  1'b1, 4'd3},  // R3 full countdown from fall
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd3},  // R3 expires on edge T
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 4'd8},  // R8 counting, high
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 4'd3},  // R3 re-kick mid count
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 4'd3},  // R3 eight edges after re-kick
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd3},  // R3 expiry from re-kick
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd2,  1'b1, 4'd8},  // R8 kicked again
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 4'd6},  // R6 supply loss, immediate low
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd0,  1'b1, 4'd6},  // R6 immediate release
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd20, 1'b1, 4'd4},  // R4 held, transition ignored
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd20, 1'b1, 4'd4},  // R4 no count after release
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd9,  1'b0, 4'd4},  // R4 counts after transition
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  1'b1, 4'd5},  // R5 disable clears expiry
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd20, 1'b1, 4'd5},  // R5 transitions ignored
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 1'b1, 4'd5},  // R5 transitions ignored
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd20, 1'b1, 4'd5},  // R5 no count without transition
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd8,  1'b1, 4'd1},  // R1 boundary
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd1},  // R1 expiry
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 4'd6},  // R6 supply low while expired
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  1'b0, 4'd2},  // R2 still expired after supply dip
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 4'd4}   // R4 reset flag clears expiry
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic exp);
    n_chk++;
    if (wdo_n !== exp) begin
      n_fail++;
      $display("FAIL %s: wdo_n=%b expected %b", tag, wdo_n, exp);
    end
  endtask

  initial begin
    step(3);
    chk("R9 reset state", 1'b1);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NV; i++) begin
      wdi         = VEC[i].wdi;
      sys_rst_act = VEC[i].srst;
      wd_en       = VEC[i].en;
      supply_ok   = VEC[i].sup;
      step(int'(VEC[i].cyc));
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
    end
    sys_rst_act = 1'b0;

    // R7 one-cycle pulse: both edges kick, the second restarts the count
    wdi = 1'b1;
    step(9);
    chk("R7 setup expiry", 1'b0);
    wdi = 1'b0;
    step(1);
    chk("R7 first edge of pulse", 1'b1);
    wdi = 1'b1;
    step(1);
    step(7);
    chk("R7 countdown from second edge", 1'b1);
    step(1);
    chk("R7 expiry from second edge", 1'b0);

    // R9 synchronous reset clears expiry, no spurious kick at release
    rst_n = 1'b0;
    wdi = 1'b0;
    step(2);
    chk("R9 reset clears expiry", 1'b1);
    rst_n = 1'b1;
    step(20);
    chk("R9 no kick at release", 1'b1);
    supply_ok = 1'b0;
    rst_n = 1'b0;
    step(1);
    chk("R9 reset with supply low", 1'b0);
    supply_ok = 1'b1;
    rst_n = 1'b1;
    step(1);
    chk("R8 idle after reset with supply", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule